// File: doc/BRIEF.md
# Command-Indexed Control Register Front End

This block turns the byte stream of a two-wire serial slave into writes to eleven 7-bit control registers. The bit-level slave in front of it flags a start condition and hands over each received byte. The first byte after a start is the device address. Only the write address 0x7C (7-bit address 0x3E with the direction bit clear) opens the transaction for writes. The read address 0x7D, or any other address, makes the block ignore the rest of that transaction.

Inside a write transaction, a byte whose upper nibble is all ones selects a register index held in a sticky pointer. The pointer survives across transactions until a new selection arrives. A byte with bit 7 clear is data: its low seven bits load the register under the pointer, and the pointer then steps to the next index. Past the last register the pointer parks, and further data is dropped. Register 0 carries two control bits. Bit 0, when written as 1, clears every register at once and pulses a soft-reset output. Bit 2 drives the test-mode output, which software is expected to keep at 0. The external reset clears everything.

Top module: `ctl_cmd_regs`

## Requirements
- R1: While rst_n is low, and after it rises, every register reads 0, soft_rst_o and test_mode_o are 0, and the pointer is 0, so the first data byte after reset lands in register 0.
- R2: A byte changes state only inside a transaction whose first byte after start_i is 0x7C. Bytes that arrive before any start, and every byte of a transaction addressed with 0x7D or any other value, leave all registers and the pointer unchanged.
- R3: A byte 0xF0 + c with c from 0 to 10 sets the pointer to c and changes no register.
- R4: The pointer keeps its value across transactions until another valid selection byte arrives.
- R5: A data byte (bit 7 = 0) writes its bits 6..0 to the register under the pointer, visible the cycle after it is accepted, and then the pointer advances by one. Register i sits at cfg_o bits [7i+6:7i].
- R6: A byte 0xF0 + c with c from 11 to 15 is ignored: the pointer and the registers keep their values.
- R7: A byte with bit 7 = 1 and an upper nibble other than 0xF (0x80 to 0xEF) is ignored entirely.
- R8: After register 10 has been written, the pointer parks, and data bytes are dropped until the next valid selection.
- R9: A data byte with bit 0 = 1 written while the pointer is 0 clears all eleven registers, including register 0. soft_rst_o is 1 for exactly the one cycle that follows, and the pointer then stands at 1.
- R10: test_mode_o follows bit 2 of register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all state |
| start_i | input | 1 | One-cycle flag: a start condition was seen, the next byte is an address |
| byte_vld_i | input | 1 | A received byte is presented on byte_i this cycle |
| byte_i | input | 8 | Received byte |
| cfg_o | output | 77 | Eleven 7-bit registers, register i at bits [7i+6:7i] |
| soft_rst_o | output | 1 | One-cycle pulse after a register-clearing write |
| test_mode_o | output | 1 | Test-mode control, bit 2 of register 0 |

## Verification
The assertions watch the pointer on every cycle. They check that it never leaves the range 0 to 11, that a parked pointer stays parked until a selection, that a selection loads the decoded index without touching a register, and that each accepted data byte steps it by one. They also check that nothing changes outside a write transaction and that the soft-reset pulse is a single cycle with all registers already at zero. Which register a given data byte lands in, the sticky pointer across transactions, the rejection of the out-of-range and malformed selection codes, and the test-mode output can only be shown by the bench's byte sequences. The bench compares each of these against a model of the requirements.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_WRITE = 2'd2,
    PH_SKIP  = 2'd3
  } phase_e;

  localparam logic [3:0] SEL_NIBBLE = 4'hF;

  // a selection byte names an index inside the register file
  function automatic logic is_select(input logic [7:0] b, input int n_regs);
    return (b[7:4] == SEL_NIBBLE) && (int'(b[3:0]) < n_regs);
  endfunction

  // data bytes carry a clear top bit
  function automatic logic is_data(input logic [7:0] b);
    return !b[7];
  endfunction

  // write address on the wire: 7-bit address followed by a 0 direction bit
  function automatic logic [7:0] write_code(input logic [6:0] dev);
    return {dev, 1'b0};
  endfunction

endpackage

// File: rtl/ccr_addr_gate.sv
module ccr_addr_gate
  import ccr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       write_phase_o,
  output logic       body_vld_o
);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (start_i) begin
      phase_d = PH_ADDR;
    end else if (byte_vld_i && (phase_q == PH_ADDR)) begin
      phase_d = (byte_i == write_code(DEV_ADDR)) ? PH_WRITE : PH_SKIP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign write_phase_o = (phase_q == PH_WRITE);
  assign body_vld_o    = byte_vld_i && !start_i && (phase_q == PH_WRITE);

endmodule

// File: rtl/ccr_byte_class.sv
module ccr_byte_class
  import ccr_pkg::*;
#(
  parameter int NUM_CMDS = 11,
  parameter int PTR_W    = 4
) (
  input  logic             body_vld_i,
  input  logic [7:0]       byte_i,
  output logic             sel_fire_o,
  output logic             data_fire_o,
  output logic [PTR_W-1:0] sel_idx_o
);

  assign sel_fire_o  = body_vld_i && is_select(byte_i, NUM_CMDS);
  assign data_fire_o = body_vld_i && is_data(byte_i);
  assign sel_idx_o   = PTR_W'(byte_i[3:0]);

endmodule

// File: rtl/ccr_cmd_ptr.sv
module ccr_cmd_ptr #(
  parameter int NUM_CMDS = 11,
  parameter int PTR_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_fire_i,
  input  logic [PTR_W-1:0] sel_idx_i,
  input  logic             data_fire_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_hit_o
);

  localparam logic [PTR_W-1:0] PARK = PTR_W'(NUM_CMDS);

  logic [PTR_W-1:0] ptr_q;

  assign wr_hit_o = data_fire_i && (ptr_q < PARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr_q <= '0;
    else if (sel_fire_i) ptr_q <= sel_idx_i;
    else if (wr_hit_o)   ptr_q <= ptr_q + PTR_W'(1);
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/ccr_reg_bank.sv
module ccr_reg_bank #(
  parameter int NUM_CMDS = 11,
  parameter int REG_W    = 7,
  parameter int PTR_W    = 4,
  parameter int CLR_BIT  = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_hit_i,
  input  logic [PTR_W-1:0]          ptr_i,
  input  logic [REG_W-1:0]          data_i,
  output logic                      soft_clr_o,
  output logic [NUM_CMDS*REG_W-1:0] cfg_o
);

  assign soft_clr_o = wr_hit_i && (ptr_i == '0) && data_i[CLR_BIT];

  for (genvar i = 0; i < NUM_CMDS; i++) begin : g_reg
    logic [REG_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  val_q <= '0;
      else if (soft_clr_o)                         val_q <= '0;
      else if (wr_hit_i && (ptr_i == PTR_W'(i)))   val_q <= data_i;
    end
    assign cfg_o[i*REG_W +: REG_W] = val_q;
  end

endmodule

// File: rtl/ctl_cmd_regs.sv
module ctl_cmd_regs #(
  parameter int         NUM_CMDS = 11,
  parameter int         REG_W    = 7,
  parameter logic [6:0] DEV_ADDR = 7'h3E,
  parameter int         CLR_BIT  = 0,
  parameter int         TEST_BIT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      byte_vld_i,
  input  logic [7:0]                byte_i,
  output logic [NUM_CMDS*REG_W-1:0] cfg_o,
  output logic                      soft_rst_o,
  output logic                      test_mode_o
);

  localparam int PTR_W = $clog2(NUM_CMDS + 1);

  logic             write_phase;
  logic             body_vld;
  logic             sel_fire;
  logic             data_fire;
  logic [PTR_W-1:0] sel_idx;
  logic [PTR_W-1:0] ptr;
  logic             wr_hit;
  logic             soft_clr;
  logic             soft_rst_q;

  ccr_addr_gate #(.DEV_ADDR(DEV_ADDR)) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .byte_vld_i    (byte_vld_i),
    .byte_i        (byte_i),
    .write_phase_o (write_phase),
    .body_vld_o    (body_vld)
  );

  ccr_byte_class #(.NUM_CMDS(NUM_CMDS), .PTR_W(PTR_W)) u_class (
    .body_vld_i  (body_vld),
    .byte_i      (byte_i),
    .sel_fire_o  (sel_fire),
    .data_fire_o (data_fire),
    .sel_idx_o   (sel_idx)
  );

  ccr_cmd_ptr #(.NUM_CMDS(NUM_CMDS), .PTR_W(PTR_W)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_fire_i  (sel_fire),
    .sel_idx_i   (sel_idx),
    .data_fire_i (data_fire),
    .ptr_o       (ptr),
    .wr_hit_o    (wr_hit)
  );

  ccr_reg_bank #(
    .NUM_CMDS (NUM_CMDS),
    .REG_W    (REG_W),
    .PTR_W    (PTR_W),
    .CLR_BIT  (CLR_BIT)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit_i   (wr_hit),
    .ptr_i      (ptr),
    .data_i     (byte_i[REG_W-1:0]),
    .soft_clr_o (soft_clr),
    .cfg_o      (cfg_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_rst_q <= 1'b0;
    else        soft_rst_q <= soft_clr;
  end

  assign soft_rst_o  = soft_rst_q;
  assign test_mode_o = cfg_o[TEST_BIT];

endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
  parameter int NUM_CMDS = 11,
  parameter int REG_W    = 7,
  parameter int PTR_W    = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      write_phase,
  input logic                      sel_fire,
  input logic                      data_fire,
  input logic [PTR_W-1:0]          sel_idx,
  input logic [PTR_W-1:0]          ptr,
  input logic [NUM_CMDS*REG_W-1:0] cfg,
  input logic                      soft_rst
);

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) <= NUM_CMDS); // R8

  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ptr) == NUM_CMDS && !sel_fire) |=> int'(ptr) == NUM_CMDS); // R8

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fire |=> ptr == $past(sel_idx)); // R3

  AST_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fire |=> $stable(cfg)); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && int'(ptr) < NUM_CMDS) |=> ptr == $past(ptr) + PTR_W'(1)); // R5

  AST_NO_WRITE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !write_phase |=> $stable(cfg)); // R2

  AST_SOFT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> cfg == '0); // R9

  AST_SOFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst); // R9

endmodule

bind ctl_cmd_regs ccr_checker #(
  .NUM_CMDS (NUM_CMDS),
  .REG_W    (REG_W),
  .PTR_W    (PTR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .write_phase (write_phase),
  .sel_fire    (sel_fire),
  .data_fire   (data_fire),
  .sel_idx     (sel_idx),
  .ptr         (ptr),
  .cfg         (cfg_o),
  .soft_rst    (soft_rst_o)
);

// File: tb/ctl_cmd_regs_tb.sv
`timescale 1ns/1ps
module ctl_cmd_regs_tb;

  localparam int N = 11;
  localparam int W = 7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic           byte_vld_i = 1'b0;
  logic [7:0]     byte_i = '0;
  logic [N*W-1:0] cfg_o;
  logic           soft_rst_o;
  logic           test_mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state, written from the requirements
  logic [W-1:0] m_reg [N];
  int  m_ptr;
  int  m_phase;  // 0 idle, 1 address expected, 2 write, 3 skip
  bit  m_soft;

  always #2 clk = ~clk;

  ctl_cmd_regs u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .cfg_o       (cfg_o),
    .soft_rst_o  (soft_rst_o),
    .test_mode_o (test_mode_o)
  );

  function automatic logic [N*W-1:0] m_vec();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = m_reg[i];
    return v;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < N; i++) m_reg[i] = '0;
  endtask

  task automatic m_byte(input logic [7:0] b);
    m_soft = 1'b0;
    if (m_phase == 1) begin
      m_phase = (b == 8'h7C) ? 2 : 3;
    end else if (m_phase == 2) begin
      if (b[7:4] == 4'hF && b[3:0] <= 4'd10) begin
        m_ptr = b[3:0];
      end else if (!b[7] && m_ptr < N) begin
        if (m_ptr == 0 && b[0]) begin
          m_clear();
          m_soft = 1'b1;
        end else begin
          m_reg[m_ptr] = b[6:0];
        end
        m_ptr++;
      end
    end
  endtask

  task automatic chk_cfg(input string tag);
    checks++;
    if (cfg_o !== m_vec()) begin
      errors++;
      $display("FAIL %s cfg actual=%h expected=%h", tag, cfg_o, m_vec());
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    byte_i = b;
    byte_vld_i = 1'b1;
    @(negedge clk);
    byte_vld_i = 1'b0;
    m_byte(b);
  endtask

  task automatic start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    m_phase = 1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    m_clear();
    m_ptr = 0;
    m_phase = 0;
    m_soft = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk_cfg("R1 reset registers");
    chk_bit("R1 reset soft_rst_o", soft_rst_o, 1'b0);
    chk_bit("R1 reset test_mode_o", test_mode_o, 1'b0);

    // bytes before any start are ignored
    send(8'h05);
    send(8'hF3);
    chk_cfg("R2 bytes before start");

    // first data after reset lands in register 0
    start();
    send(8'h7C);
    send(8'h04);
    chk_cfg("R1 pointer at 0 after reset");
    chk_bit("R10 test_mode_o set", test_mode_o, 1'b1);

    // auto-increment through registers 1..10
    for (int v = 1; v < N; v++) begin
      send(8'((v * 11 + 2) & 8'h7F));
      chk_cfg("R5 auto-increment write");
    end
    send(8'h2A);
    chk_cfg("R8 data dropped when parked");

    // every valid selection, then one data byte (bit 0 kept clear)
    for (int c = 0; c < N; c++) begin
      send(8'hF0 | 8'(c));
      chk_cfg("R3 selection writes nothing");
      send(8'((c * 22 + 6) & 8'h7E));
      chk_cfg("R3 data lands at selected index");
    end
    chk_bit("R10 test_mode_o follows reg0 bit 2", test_mode_o, m_reg[0][2]);
    send(8'h15);
    chk_cfg("R8 dropped after register 10");

    // out-of-range selections keep the pointer
    send(8'hF3);
    for (int c = 11; c < 16; c++) send(8'hF0 | 8'(c));
    chk_cfg("R6 out-of-range selections");
    send(8'h41);
    chk_cfg("R6 pointer kept at 3");

    // malformed high bytes are ignored
    for (int b = 8'h80; b < 8'hF0; b++) send(8'(b));
    chk_cfg("R7 malformed bytes ignored");
    send(8'h22);
    chk_cfg("R7 pointer kept at 4");

    // read address and foreign address
    start();
    send(8'h7D);
    send(8'h11);
    send(8'hF2);
    send(8'h33);
    chk_cfg("R2 read transaction ignored");
    start();
    send(8'h7E);
    send(8'h44);
    chk_cfg("R2 foreign address ignored");

    // pointer sticky across transactions (should be at 5)
    start();
    send(8'h7C);
    send(8'h66);
    chk_cfg("R4 pointer kept across transactions");

    // test mode on and off
    send(8'hF0);
    send(8'h04);
    chk_bit("R10 test_mode_o on", test_mode_o, 1'b1);
    send(8'hF0);
    send(8'h00);
    chk_bit("R10 test_mode_o off", test_mode_o, 1'b0);

    // soft reset through register 0 bit 0
    send(8'hF0);
    send(8'h01);
    chk_bit("R9 soft_rst_o pulse", soft_rst_o, 1'b1);
    chk_cfg("R9 all registers cleared");
    @(negedge clk);
    chk_bit("R9 soft_rst_o one cycle", soft_rst_o, 1'b0);
    send(8'h12);
    chk_cfg("R9 pointer at 1 after clear");

    // external reset mid-stream
    send(8'h3C);
    do_reset();
    chk_cfg("R1 external reset clears");
    start();
    send(8'h7C);
    send(8'h08);
    chk_cfg("R1 pointer back to 0");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule